// File: doc/BRIEF.md
# Single-Step Trap Sequencer

This block holds a processor's 16-bit status word and, while the step bit of that word is set, turns every retired instruction into a type-1 trap. A debugger uses it to run a program one instruction at a time: the handler inspects the machine, then resumes the program with an interrupt return whose restored status word still has the step bit set. Exactly one more instruction then runs before the trap is taken again.

The core reports each retired instruction with a one-cycle strobe. Whole-word loads of the status word (pop-flags and interrupt return) arrive on a load port, in the same cycle as the retire strobe of the loading instruction or earlier. When a trap is due, the block runs the entry sequence. It writes three words to the stack through a request/acknowledge handshake, clears the step and interrupt-enable bits, and presents the vector number, the vector-table byte address and the new stack pointer for one cycle.

Top module: `step_trap_unit`

## Requirements
- R1: After reset the status word reads 0xF002, and stkWrReq, busy and vecValid are low.
- R2: A load keeps the bits of flagsIn at the defined positions 0, 2, 4, 6, 7, 8, 9, 10 and 11, and ignores the others. Bit 1 and bits 12 to 15 always read 1, and bits 3 and 5 always read 0. The load is visible on flags in the cycle after the load strobe.
- R3: A retire with the step bit (bit 8) clear at the start of the instruction starts no entry sequence.
- R4: The step state of an instruction is the value of bit 8 after the previous retire's load. A retire that loads a word with bit 8 set does not trap. A retire whose step state is set traps, even when it loads a word with bit 8 clear.
- R5: The entry writes three words in a fixed order. The status word, as it stands after the trapping retire's load, goes to stackPtr-2. retSeg goes to stackPtr-4 and retOff goes to stackPtr-6. All three values are sampled at the trapping retire.
- R6: stkWrReq stays high, with stkAddr and stkData unchanged, until stkWrAck is seen high at a clock edge. Each acknowledged write advances the sequence by one word.
- R7: In the cycle after the third acknowledge, vecValid is high for exactly one cycle. In that cycle vecNum is 1, vecAddr is 0x0004 and newSp is stackPtr-6. Bits 8 and 9 of flags read 0 and all other bits keep their values.
- R8: After entry, retires trap no more until a load sets bit 8. An interrupt return loading a word with bit 8 set lets exactly one further instruction run before the next trap.
- R9: retire and flagsLoad are ignored while busy is high. The status word and the sequence are unaffected by them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| retire | input | 1 | One-cycle strobe per retired instruction |
| flagsLoad | input | 1 | Whole-word status load strobe |
| flagsIn | input | 16 | Status word to load |
| stackPtr | input | 16 | Current stack pointer, sampled at the trap |
| retSeg | input | 16 | Return segment, sampled at the trap |
| retOff | input | 16 | Return offset, sampled at the trap |
| stkWrReq | output | 1 | Stack write request |
| stkAddr | output | 16 | Stack write byte address |
| stkData | output | 16 | Stack write data |
| stkWrAck | input | 1 | Stack write acknowledge |
| busy | output | 1 | Entry sequence in progress |
| flags | output | 16 | Current status word |
| vecValid | output | 1 | One-cycle entry-complete pulse |
| vecNum | output | 8 | Vector number |
| vecAddr | output | 16 | Vector-table byte address |
| newSp | output | 16 | Stack pointer after the three writes |

## Verification
A sweep loads four thousand status words. It shows that the defined bits pass through and the reserved bits stay fixed. Entries are run over eight stack pointers, eight status images and acknowledge delays of zero to three cycles, which checks the write order, the address step, and the hold of request, address and data while unacknowledged. Pop-flags loads that set the step bit on the retiring instruction, or clear it there, separate the step state at instruction start from the state after the load. Retire and load strobes injected during an entry show that a busy sequence ignores them.

// File: rtl/step_trap_pkg.sv
package step_trap_pkg;
  localparam int WORD_W = 16;
  localparam int TF_BIT = 8;
  localparam int IE_BIT = 9;
  localparam logic [WORD_W-1:0] DEF_MASK   = 16'h0FD5;
  localparam logic [WORD_W-1:0] FIXED_ONES = 16'hF002;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PUSH_FL, ST_PUSH_SEG, ST_PUSH_OFF, ST_DONE
  } seqState_t;

  typedef struct packed {
    logic       acceptIn;
    logic       capture;
    logic       clearTfIe;
    logic [1:0] slot;
  } seqCtl_t;
endpackage

// File: rtl/step_trap_dp.sv
module step_trap_dp
  import step_trap_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic              retire,
  input  logic              flagsLoad,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] stackPtr,
  input  logic [WORD_W-1:0] retSeg,
  input  logic [WORD_W-1:0] retOff,
  output logic [WORD_W-1:0] flags,
  output logic              tfStart,
  output logic [WORD_W-1:0] stkAddr,
  output logic [WORD_W-1:0] stkData,
  output logic [WORD_W-1:0] newSp
);
  localparam logic [WORD_W-1:0] STEP2 = WORD_W'(2);
  localparam logic [WORD_W-1:0] STEP4 = WORD_W'(4);
  localparam logic [WORD_W-1:0] STEP6 = WORD_W'(6);

  logic [WORD_W-1:0] flagsQ, imgQ, spQ, segQ, offQ;
  logic              tfStartQ;
  logic [WORD_W-1:0] flagsNext;

  always_comb begin
    flagsNext = flagsQ;
    if (ctl.acceptIn && flagsLoad)
      flagsNext = (flagsIn & DEF_MASK) | FIXED_ONES;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagsQ   <= FIXED_ONES;
      tfStartQ <= 1'b0;
      imgQ     <= '0;
      spQ      <= '0;
      segQ     <= '0;
      offQ     <= '0;
    end else begin
      if (ctl.acceptIn) begin
        flagsQ <= flagsNext;
        if (retire) tfStartQ <= flagsNext[TF_BIT];
      end
      if (ctl.capture) begin
        imgQ <= flagsNext;
        spQ  <= stackPtr;
        segQ <= retSeg;
        offQ <= retOff;
      end
      if (ctl.clearTfIe) begin
        flagsQ[TF_BIT] <= 1'b0;
        flagsQ[IE_BIT] <= 1'b0;
        tfStartQ       <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (ctl.slot)
      2'd1:    begin stkAddr = spQ - STEP4; stkData = segQ; end
      2'd2:    begin stkAddr = spQ - STEP6; stkData = offQ; end
      default: begin stkAddr = spQ - STEP2; stkData = imgQ; end
    endcase
  end

  assign flags   = flagsQ;
  assign tfStart = tfStartQ;
  assign newSp   = spQ - STEP6;
endmodule

// File: rtl/step_trap_ctrl.sv
module step_trap_ctrl
  import step_trap_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    retire,
  input  logic    tfStart,
  input  logic    stkWrAck,
  output seqCtl_t ctl,
  output logic    stkWrReq,
  output logic    busy,
  output logic    vecValid
);
  seqState_t state, stateNext;
  logic      idle, pushing, accepted;

  assign idle     = (state == ST_IDLE);
  assign pushing  = (state == ST_PUSH_FL) || (state == ST_PUSH_SEG) || (state == ST_PUSH_OFF);
  assign accepted = pushing && stkWrAck;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:     if (retire && tfStart) stateNext = ST_PUSH_FL;
      ST_PUSH_FL:  if (accepted) stateNext = ST_PUSH_SEG;
      ST_PUSH_SEG: if (accepted) stateNext = ST_PUSH_OFF;
      ST_PUSH_OFF: if (accepted) stateNext = ST_DONE;
      default:     stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    ctl.acceptIn  = idle;
    ctl.capture   = idle && retire && tfStart;
    ctl.clearTfIe = (state == ST_PUSH_OFF) && stkWrAck;
    unique case (state)
      ST_PUSH_SEG: ctl.slot = 2'd1;
      ST_PUSH_OFF: ctl.slot = 2'd2;
      default:     ctl.slot = 2'd0;
    endcase
  end

  assign stkWrReq = pushing;
  assign busy     = !idle;
  assign vecValid = (state == ST_DONE);
endmodule

// File: rtl/step_trap_unit.sv
module step_trap_unit
  import step_trap_pkg::*;
#(
  parameter int VEC_TYPE = 1,
  parameter int VEC_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              retire,
  input  logic              flagsLoad,
  input  logic [WORD_W-1:0] flagsIn,
  input  logic [WORD_W-1:0] stackPtr,
  input  logic [WORD_W-1:0] retSeg,
  input  logic [WORD_W-1:0] retOff,
  output logic              stkWrReq,
  output logic [WORD_W-1:0] stkAddr,
  output logic [WORD_W-1:0] stkData,
  input  logic              stkWrAck,
  output logic              busy,
  output logic [WORD_W-1:0] flags,
  output logic              vecValid,
  output logic [VEC_W-1:0]  vecNum,
  output logic [WORD_W-1:0] vecAddr,
  output logic [WORD_W-1:0] newSp
);
  localparam logic [VEC_W-1:0]  VEC_NUM  = VEC_W'(VEC_TYPE);
  localparam logic [WORD_W-1:0] VEC_BYTE = WORD_W'(VEC_TYPE * 4);

  seqCtl_t ctl;
  logic    tfStart;

  step_trap_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .retire(retire), .tfStart(tfStart),
    .stkWrAck(stkWrAck), .ctl(ctl), .stkWrReq(stkWrReq),
    .busy(busy), .vecValid(vecValid)
  );

  step_trap_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .retire(retire),
    .flagsLoad(flagsLoad), .flagsIn(flagsIn), .stackPtr(stackPtr),
    .retSeg(retSeg), .retOff(retOff), .flags(flags), .tfStart(tfStart),
    .stkAddr(stkAddr), .stkData(stkData), .newSp(newSp)
  );

  assign vecNum  = VEC_NUM;
  assign vecAddr = VEC_BYTE;
endmodule

// File: rtl/step_trap_chk.sv
module step_trap_chk
  import step_trap_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stkWrReq,
  input logic [WORD_W-1:0] stkAddr,
  input logic [WORD_W-1:0] stkData,
  input logic              stkWrAck,
  input logic              busy,
  input logic [WORD_W-1:0] flags,
  input logic              vecValid,
  input logic [VEC_W-1:0]  vecNum,
  input logic [WORD_W-1:0] vecAddr,
  input logic [WORD_W-1:0] newSp
);
  p_fixed_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (flags & ~DEF_MASK) == FIXED_ONES);

  p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !stkWrReq && !vecValid);

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    stkWrReq && stkWrAck |=> !stkWrReq || (stkAddr == $past(stkAddr) - 16'd2));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    stkWrReq && !stkWrAck |=> stkWrReq && $stable(stkAddr) && $stable(stkData));

  p_vector_r7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> !flags[TF_BIT] && !flags[IE_BIT]
                 && vecAddr == WORD_W'({vecNum, 2'b00}) && newSp == $past(stkAddr));

  p_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  p_ignore_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(busy) && !vecValid |-> $stable(flags));
endmodule

bind step_trap_unit step_trap_chk #(.VEC_W(VEC_W)) u_chk (
  .clk(clk), .rstN(rstN), .stkWrReq(stkWrReq), .stkAddr(stkAddr),
  .stkData(stkData), .stkWrAck(stkWrAck), .busy(busy), .flags(flags),
  .vecValid(vecValid), .vecNum(vecNum), .vecAddr(vecAddr), .newSp(newSp)
);

// File: tb/step_trap_unit_tb.sv
`timescale 1ns/1ps
module step_trap_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        retire = 1'b0, flagsLoad = 1'b0, stkWrAck = 1'b0;
  logic [15:0] flagsIn = '0, stackPtr = '0, retSeg = '0, retOff = '0;
  logic        stkWrReq, busy, vecValid;
  logic [15:0] stkAddr, stkData, flags, vecAddr, newSp;
  logic [7:0]  vecNum;
  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [15:0] expFlags;

  always #4 clk = ~clk;

  step_trap_unit u_dut (
    .clk(clk), .rstN(rstN), .retire(retire), .flagsLoad(flagsLoad),
    .flagsIn(flagsIn), .stackPtr(stackPtr), .retSeg(retSeg), .retOff(retOff),
    .stkWrReq(stkWrReq), .stkAddr(stkAddr), .stkData(stkData),
    .stkWrAck(stkWrAck), .busy(busy), .flags(flags), .vecValid(vecValid),
    .vecNum(vecNum), .vecAddr(vecAddr), .newSp(newSp)
  );

  function automatic logic [15:0] fold(input logic [15:0] v);
    return (v & 16'h0FD5) | 16'hF002;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one retire cycle, optionally with a load; returns just after the next negedge
  task automatic step(input bit ld, input logic [15:0] v);
    retire = 1'b1; flagsLoad = ld; flagsIn = v;
    @(negedge clk);
    retire = 1'b0; flagsLoad = 1'b0;
    if (ld) expFlags = fold(v);
  endtask

  task automatic expectNoTrap(input string req);
    chk(!stkWrReq && !busy, req, {15'd0, stkWrReq}, 16'd0);
  endtask

  task automatic runEntry(input logic [15:0] img, input int waits, input bit inject, input string req);
    for (int k = 0; k < 3; k++) begin
      logic [15:0] eA, eD;
      eA = stackPtr - 16'(2 * (k + 1));
      eD = (k == 0) ? img : (k == 1) ? retSeg : retOff;
      while (!stkWrReq) @(negedge clk);
      chk(stkAddr == eA, {req, " R5 addr"}, stkAddr, eA);
      chk(stkData == eD, {req, " R5 data"}, stkData, eD);
      for (int w = 0; w < waits; w++) begin
        if (inject) begin retire = 1'b1; flagsLoad = 1'b1; flagsIn = ~img; end
        @(negedge clk);
        retire = 1'b0; flagsLoad = 1'b0;
        chk(stkWrReq && stkAddr == eA && stkData == eD, {req, " R6 hold"}, stkAddr, eA);
      end
      stkWrAck = 1'b1;
      @(negedge clk);
      stkWrAck = 1'b0;
    end
    expFlags = expFlags & 16'hFCFF;
    chk(vecValid == 1'b1, {req, " R7 valid"}, {15'd0, vecValid}, 16'd1);
    chk(vecNum == 8'd1 && vecAddr == 16'h0004, {req, " R7 vector"}, vecAddr, 16'h0004);
    chk(newSp == stackPtr - 16'd6, {req, " R7 newSp"}, newSp, stackPtr - 16'd6);
    chk(flags == expFlags, {req, " R7/R9 flags"}, flags, expFlags);
    @(negedge clk);
    chk(!vecValid && !busy && !stkWrReq, {req, " R7 pulse/R9 no restart"}, {15'd0, vecValid}, 16'd0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      summary();
      $finish;
    end
  end

  initial begin
    logic [15:0] img;
    repeat (3) @(negedge clk);
    chk(flags == 16'hF002 && !stkWrReq && !busy && !vecValid, "R1 in reset", flags, 16'hF002);
    rstN = 1'b1;
    @(negedge clk);
    chk(flags == 16'hF002 && !stkWrReq && !busy && !vecValid, "R1 after reset", flags, 16'hF002);
    expFlags = 16'hF002;

    // R2: load sweep, no retire
    for (int i = 0; i < 4096; i++) begin
      logic [15:0] v;
      v = 16'(i * 16) | 16'((i * 7) & 15);
      flagsLoad = 1'b1; flagsIn = v;
      @(negedge clk);
      chk(flags == fold(v), "R2 load mask", flags, fold(v));
    end
    flagsLoad = 1'b0;
    expFlags = fold(flagsIn);
    step(1'b1, 16'h0000);
    expectNoTrap("R3 load clear");

    // R3: defined bits set but step bit clear
    step(1'b1, 16'h0ED5);
    expectNoTrap("R3 no step");
    for (int i = 0; i < 4; i++) begin
      step(1'b0, 16'h0);
      expectNoTrap("R3 plain retire");
    end

    // R4: pop-flags setting the step bit does not trap after itself
    stackPtr = 16'h0100; retSeg = 16'h1234; retOff = 16'h5678;
    step(1'b1, 16'h0FD5);
    expectNoTrap("R4 set on retire");
    img = expFlags;
    step(1'b0, 16'h0);
    runEntry(img, 0, 1'b0, "R4 first trap");

    // R8: handler runs unstepped, iret resumes for one instruction
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 16'h0);
      expectNoTrap("R8 handler");
    end
    step(1'b1, img);
    expectNoTrap("R8 iret");
    stackPtr = 16'h0002; retSeg = 16'hBEEF; retOff = 16'h0001;
    step(1'b0, 16'h0);
    runEntry(img, 2, 1'b1, "R8 step again / R9 inject");

    // R4: clearing the step bit on a stepped retire still traps
    step(1'b1, img);
    expectNoTrap("R8 iret 2");
    stackPtr = 16'hFFF0;
    step(1'b1, img & 16'hFEFF);
    runEntry(fold(img & 16'hFEFF), 1, 1'b0, "R4 clear on retire");
    step(1'b0, 16'h0);
    expectNoTrap("R8 stepping ended");

    // sweep over stack pointers, images and acknowledge delays
    for (int j = 0; j < 8; j++) begin
      logic [15:0] v;
      v = 16'(j * 16'h1357) | 16'h0100;
      stackPtr = 16'(j * 16'h2222 + 4);
      retSeg = 16'(j * 16'h0F0F); retOff = ~16'(j * 16'h0101);
      step(1'b1, v);
      expectNoTrap("R4 sweep set");
      img = expFlags;
      step(1'b0, 16'h0);
      runEntry(img, j % 4, (j % 2) == 1, "R5 sweep");
    end

    finished = 1'b1;
    summary();
    $finish;
  end
endmodule